// File: doc/BRIEF.md
# Burst Pseudo-SRAM Host Controller

This block sits between a simple on-chip request port and an external pseudo-SRAM that runs in clocked burst mode. Out of reset it programs the memory's bus configuration register once, through a clocked write with the register-select pin raised. That write puts the device into variable-latency burst operation with WAIT active high and WAIT leading the data by one clock. Only after this does it open the request port.

Each accepted request becomes one burst. There is a single clock with the address strobe low and the address on the bus. Chip enable then stays low until the requested number of words has moved, and is raised afterwards. The memory's WAIT pin is the only thing that tells the controller which clocks carry data. Read words come out on a one-cycle valid pulse. Write words are pulled from the requester with an acknowledge pulse. If WAIT stays active for too long inside one burst, the burst is abandoned and an error pulse is raised.

The memory shares the controller clock. The data bus is split into an input, an output and an output enable for an external pad.

Top module: `psram_burst_host`

## Requirements
- R1: After reset, before `req_ready` is ever high, exactly one register write is issued for one clock with `mem_cre`, `mem_ce_n`=0, `mem_adv_n`=0 and `mem_we_n`=0. Its address has bits [19:18]=10 and carries the configuration word in bits [15:0]. In that word bit 15=0 selects burst operation, bit 14=0 selects variable latency, bits [13:11] hold LAT_CLKS-1 (3, 4 or 5 clocks), bit 10=1 makes WAIT active high, bit 8=1 makes WAIT lead data by one clock, bits [5:4]=01 select half drive, bit 3=1 and bits [2:0]=111 select continuous non-wrapping bursts, and all other bits are 0 (0x8251F for 5 clocks).
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is never high while `mem_ce_n` is low, and `mem_ce_n` stays high for at least two clocks between bursts.
- R3: Every burst has exactly one clock with `mem_adv_n` low. During that clock `mem_ce_n` is low, `mem_cre` is low and `mem_addr` carries the request address. `mem_ce_n` then stays low without a break until the burst ends.
- R4: On a read, a word is taken from `mem_dq_in` at the edge that closes the clock following a `mem_wait` sample of 0. The word appears on `rd_data` with a one-clock `rd_valid` pulse. Words arrive in address order, and clocks in which WAIT was active deliver nothing.
- R5: On a write, `wr_ack` pulses (combinationally) at each edge where `mem_wait` is sampled 0 in the data phase. `wr_data` is captured at that edge and driven on `mem_dq_out` with `mem_dq_oe`=1 for the following clock.
- R6: `mem_ub_n` and `mem_lb_n` are both 0 whenever `mem_ce_n` is 0 outside the register write.
- R7: A burst moves exactly `req_len`+1 words (`req_len` ranges 0 to 31), and `mem_ce_n` goes high on the clock after the last word.
- R8: `mem_oe_n` is 0 only in read bursts. It is 0 only when `mem_dq_oe` is 0 in that clock and was 0 in the previous clock, and `mem_we_n` is 1 whenever `mem_oe_n` is 0.
- R9: If `mem_wait` is sampled active on more than 16 consecutive data-phase edges, `timeout_err` pulses for one clock, `mem_ce_n` is high in that clock, and the burst delivers no more words. A run of exactly 16 produces no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Word address of the burst start |
| req_write | input | 1 | 1 for a write burst, 0 for a read |
| req_len | input | LEN_W | Word count minus one |
| wr_data | input | DATA_W | Next write word |
| wr_ack | output | 1 | Write word consumed at this edge |
| rd_data | output | DATA_W | Read word |
| rd_valid | output | 1 | `rd_data` holds a new word |
| timeout_err | output | 1 | Burst abandoned on WAIT timeout |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cre | output | 1 | Register-select pin |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_wait | input | 1 | WAIT from the memory, active high |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_oe | output | 1 | Output enable for the data pads |
| mem_dq_in | input | DATA_W | Data received from the memory |

## Verification
The main function is tried with a memory model whose WAIT pattern the bench chooses per burst. Four kinds of pattern are used. A plain initial latency shows whether the controller finds the first data clock by WAIT alone. A mid-burst stall of a few clocks separates a controller that stretches correctly from one that counts clocks; the model returns a poison value in stalled clocks. Random mixes of latency, stall position, length and direction cover both the one-word and the 32-word extremes. A stall of exactly 16 versus 17 clocks pins the timeout threshold. Writes are checked by reading the model's array back, and reads against the model's preloaded contents.

// File: rtl/psram_host_pkg.sv
package psram_host_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_CFG_ADDR,
    ST_CFG_HOLD,
    ST_GAP,
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_TAIL
  } host_state_e;

  // Configuration word written once after reset.
  function automatic logic [15:0] cfg_word(input int unsigned lat_clks);
    logic [15:0] w;
    w        = '0;
    w[15]    = 1'b0;            // clocked burst operation
    w[14]    = 1'b0;            // variable latency
    w[13:11] = 3'(lat_clks - 1);
    w[10]    = 1'b1;            // WAIT active high
    w[8]     = 1'b1;            // WAIT one clock ahead of data
    w[5:4]   = 2'b01;           // half drive
    w[3]     = 1'b1;            // no wrap
    w[2:0]   = 3'b111;          // continuous
    return w;
  endfunction

endpackage

// File: rtl/psram_cfg_word.sv
module psram_cfg_word
  import psram_host_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int LAT_CLKS = 5
) (
  output logic [ADDR_W-1:0] cfg_addr
);
  localparam logic [15:0] CfgBits = cfg_word(LAT_CLKS);

  generate
    if (ADDR_W >= 20) begin : g_wide
      always_comb begin
        cfg_addr        = '0;
        cfg_addr[15:0]  = CfgBits;
        cfg_addr[19:18] = 2'b10;  // select bus configuration register
      end
    end else begin : g_narrow
      assign cfg_addr = '0;
    end
  endgenerate
endmodule

// File: rtl/psram_beat_ctl.sv
module psram_beat_ctl #(
  parameter int LEN_W    = 5,
  parameter int TMO_CLKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             mem_wait,
  input  logic [LEN_W-1:0] len,
  output logic             beat,
  output logic             last,
  output logic             timeout
);
  localparam int CW = $clog2(TMO_CLKS + 1) + 1;

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [CW-1:0]    wcnt_q, wcnt_d;

  assign beat    = active && !mem_wait;
  assign last    = beat && (cnt_q == len);
  assign timeout = active && mem_wait && (wcnt_q == CW'(TMO_CLKS));

  always_comb begin
    cnt_d  = cnt_q;
    wcnt_d = wcnt_q;
    if (!active) begin
      cnt_d  = '0;
      wcnt_d = '0;
    end else if (beat) begin
      cnt_d  = cnt_q + 1'b1;
      wcnt_d = '0;
    end else if (!timeout) begin
      wcnt_d = wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wcnt_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      wcnt_q <= wcnt_d;
    end
  end
endmodule

// File: rtl/psram_burst_host.sv
module psram_burst_host
  import psram_host_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 16,
  parameter int LEN_W    = 5,
  parameter int LAT_CLKS = 5,
  parameter int TMO_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              timeout_err,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cre,
  output logic              mem_adv_n,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  input  logic              mem_wait,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  host_state_e state_q, state_d;

  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] dq_out_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              cap_pend_q, rd_valid_q, err_q;
  logic [ADDR_W-1:0] cfg_addr;
  logic              beat, last, timeout;
  logic              accept, in_cfg, in_burst, data_ph;

  psram_cfg_word #(.ADDR_W(ADDR_W), .LAT_CLKS(LAT_CLKS)) u_cfg (
    .cfg_addr (cfg_addr)
  );

  psram_beat_ctl #(.LEN_W(LEN_W), .TMO_CLKS(TMO_CLKS)) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (state_q == ST_DATA),
    .mem_wait (mem_wait),
    .len      (len_q),
    .beat     (beat),
    .last     (last),
    .timeout  (timeout)
  );

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BOOT:     state_d = ST_CFG_ADDR;
      ST_CFG_ADDR: state_d = ST_CFG_HOLD;
      ST_CFG_HOLD: state_d = ST_GAP;
      ST_GAP:      state_d = ST_IDLE;
      ST_IDLE:     if (req_valid) state_d = ST_ADDR;
      ST_ADDR:     state_d = ST_DATA;
      ST_DATA: begin
        if (timeout)   state_d = ST_GAP;
        else if (last) state_d = ST_TAIL;
      end
      ST_TAIL:     state_d = ST_GAP;
      default:     state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_BOOT;
      addr_q     <= '0;
      wr_q       <= 1'b0;
      len_q      <= '0;
      dq_out_q   <= '0;
      rd_data_q  <= '0;
      cap_pend_q <= 1'b0;
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= req_addr;
        wr_q   <= req_write;
        len_q  <= req_len;
      end
      if (beat && wr_q) dq_out_q <= wr_data;
      cap_pend_q <= beat && !wr_q;
      rd_valid_q <= cap_pend_q;
      if (cap_pend_q) rd_data_q <= mem_dq_in;
      err_q <= timeout;
    end
  end

  assign in_cfg   = (state_q == ST_CFG_ADDR) || (state_q == ST_CFG_HOLD);
  assign data_ph  = (state_q == ST_DATA) || (state_q == ST_TAIL);
  assign in_burst = (state_q == ST_ADDR) || data_ph;

  assign req_ready   = (state_q == ST_IDLE);
  assign wr_ack      = beat && wr_q;
  assign rd_data     = rd_data_q;
  assign rd_valid    = rd_valid_q;
  assign timeout_err = err_q;

  assign mem_addr   = in_cfg ? cfg_addr : addr_q;
  assign mem_cre    = in_cfg;
  assign mem_adv_n  = !((state_q == ST_CFG_ADDR) || (state_q == ST_ADDR));
  assign mem_ce_n   = !(in_cfg || in_burst);
  assign mem_we_n   = !(in_cfg || (in_burst && wr_q));
  assign mem_oe_n   = !(data_ph && !wr_q);
  assign mem_ub_n   = !in_burst;
  assign mem_lb_n   = !in_burst;
  assign mem_dq_oe  = data_ph && wr_q;
  assign mem_dq_out = dq_out_q;
endmodule

// File: rtl/psram_host_checker.sv
module psram_host_checker #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              wr_ack,
  input logic              rd_valid,
  input logic              timeout_err,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cre,
  input logic              mem_adv_n,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic              mem_wait,
  input logic              mem_dq_oe,
  input logic [DATA_W-1:0] mem_dq_out
);
  p_cfg_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cre |-> (mem_addr[19:18] == 2'b10 && !mem_we_n && !mem_ce_n));
  p_ce_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |=> mem_ce_n);
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);
  p_adv_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> mem_adv_n);
  p_adv_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> !mem_ce_n);
  p_rd_after_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_oe_n));
  p_wack_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> (!mem_wait && !mem_ce_n && !mem_we_n));
  p_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_cre) |-> (!mem_ub_n && !mem_lb_n));
  p_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && !$past(mem_dq_oe)));
  p_oe_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);
  p_to_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> mem_ce_n);

  logic unused_ok;
  assign unused_ok = ^mem_dq_out;
endmodule

bind psram_burst_host psram_host_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .wr_ack      (wr_ack),
  .rd_valid    (rd_valid),
  .timeout_err (timeout_err),
  .mem_addr    (mem_addr),
  .mem_cre     (mem_cre),
  .mem_adv_n   (mem_adv_n),
  .mem_ce_n    (mem_ce_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .mem_ub_n    (mem_ub_n),
  .mem_lb_n    (mem_lb_n),
  .mem_wait    (mem_wait),
  .mem_dq_oe   (mem_dq_oe),
  .mem_dq_out  (mem_dq_out)
);

// File: tb/tb_psram_burst_host.sv
`timescale 1ns/1ps
module tb_psram_burst_host;
  localparam int ADDR_W = 22;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 5;
  localparam int LAT    = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic [DATA_W-1:0] wr_data, rd_data, mem_dq_out, m_dq;
  logic wr_ack, rd_valid, timeout_err;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_cre, mem_adv_n, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
  logic m_wait, mem_dq_oe;

  always #2 clk = ~clk;

  psram_burst_host #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .LAT_CLKS(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_len(req_len),
    .wr_data(wr_data), .wr_ack(wr_ack), .rd_data(rd_data), .rd_valid(rd_valid),
    .timeout_err(timeout_err), .mem_addr(mem_addr), .mem_cre(mem_cre),
    .mem_adv_n(mem_adv_n), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_wait(m_wait), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(m_dq)
  );

  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wpat(input int i);
    return 16'hA5C3 ^ 16'(i * 37);
  endfunction

  function automatic logic [15:0] ipat(input int i);
    return 16'h1000 + 16'(i * 3);
  endfunction

  function automatic int exp_cfg();
    return (2 << 18) | ((LAT - 1) << 11) | (1 << 10) | (1 << 8) | (1 << 4) | (1 << 3) | 7;
  endfunction

  // ---------------- memory model ----------------
  int lat_first = LAT, st0 = 0, slen = 0;
  logic [15:0] mem [256];
  logic act, isw;
  int n, k, wbeats = 0, cfg_cnt = 0, wdrv_bad = 0;
  logic [7:0] base;
  logic [ADDR_W-1:0] cfg_val;

  function automatic bit rdy(input int c);
    return (c >= lat_first) && !((c >= st0) && (c < st0 + slen));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= ipat(i);
      act <= 1'b0; m_wait <= 1'b0; m_dq <= 16'hDEAD; n <= 0; k <= 0;
      isw <= 1'b0; base <= '0;
    end else if (mem_ce_n) begin
      act <= 1'b0; m_wait <= 1'b0; m_dq <= 16'hDEAD;
    end else if (mem_cre) begin
      if (!mem_adv_n && !mem_we_n) begin
        cfg_cnt <= cfg_cnt + 1; cfg_val <= mem_addr;
      end
    end else if (!mem_adv_n) begin
      act <= 1'b1; isw <= !mem_we_n; base <= mem_addr[7:0];
      n <= 0; k <= 0; m_wait <= !rdy(1); m_dq <= 16'hDEAD;
    end else if (act) begin
      if (isw) begin
        if (rdy(n)) begin
          mem[8'(base + 8'(k))] <= mem_dq_out;
          k <= k + 1; wbeats <= wbeats + 1;
          if (!mem_dq_oe) wdrv_bad <= wdrv_bad + 1;
        end
      end else begin
        if (rdy(n + 1)) begin
          m_dq <= mem[8'(base + 8'(k))]; k <= k + 1;
        end else m_dq <= 16'hDEAD;
      end
      m_wait <= !rdy(n + 2);
      n <= n + 1;
    end
  end

  // ---------------- monitors ----------------
  int widx = 0, ackcnt = 0, rcnt = 0, to_cnt = 0;
  bit ack_flag = 1'b0;
  logic [15:0] rbuf [1024];
  int adv_lo = 0, ce_falls = 0, gap_run = 0, min_gap = 1000, lane_bad = 0;
  int turn_bad = 0, ready_bad = 0, early_ready = 0;
  logic prev_ce = 1'b1, prev_oe_drv = 1'b0;

  always @(negedge clk) begin
    if (ack_flag) widx++;
    ack_flag = wr_ack;
    if (wr_ack) ackcnt++;
    wr_data = wpat(widx);
    if (rst_n) begin
      if (rd_valid) begin rbuf[rcnt % 1024] = rd_data; rcnt++; end
      if (timeout_err) to_cnt++;
      if (!mem_adv_n && !mem_cre) adv_lo++;
      if (prev_ce && !mem_ce_n) begin
        ce_falls++;
        if (ce_falls > 1 && gap_run < min_gap) min_gap = gap_run;
      end
      gap_run = mem_ce_n ? gap_run + 1 : 0;
      if (!mem_ce_n && !mem_cre && (mem_ub_n || mem_lb_n)) lane_bad++;
      if (!mem_oe_n && (mem_dq_oe || prev_oe_drv || !mem_we_n)) turn_bad++;
      if (req_ready && !mem_ce_n) ready_bad++;
      if (req_ready && cfg_cnt == 0) early_ready++;
      prev_ce = mem_ce_n;
      prev_oe_drv = mem_dq_oe;
    end
  end

  // ---------------- stimulus ----------------
  int bursts = 0;

  task automatic burst(input bit w, input int a, input int len, input int lf,
                       input int s0, input int sl, input bit exp_to);
    int r0, a0, w0, b0, t0, bad, first_act, first_exp;
    @(negedge clk);
    lat_first = lf; st0 = s0; slen = sl;
    r0 = rcnt; a0 = ackcnt; w0 = widx; b0 = wbeats; t0 = to_cnt;
    bursts++;
    req_write = w; req_addr = ADDR_W'(a); req_len = LEN_W'(len); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (mem_ce_n) @(negedge clk);
    while (!mem_ce_n) @(negedge clk);
    repeat (3) @(negedge clk);
    if (exp_to) begin
      check(to_cnt - t0 == 1, "R9 timeout pulse count", to_cnt - t0, 1);
      check(rcnt - r0 < len + 1, "R9 burst cut short", rcnt - r0, len);
    end else begin
      check(to_cnt == t0, "R9 no timeout", to_cnt - t0, 0);
      bad = 0; first_act = 0; first_exp = 0;
      if (w) begin
        check(wbeats - b0 == len + 1, "R7 write word count", wbeats - b0, len + 1);
        check(ackcnt - a0 == len + 1, "R5 wr_ack count", ackcnt - a0, len + 1);
        for (int i = 0; i <= len; i++)
          if (mem[8'(a + i)] !== wpat(w0 + i)) begin
            if (bad == 0) begin first_act = int'(mem[8'(a + i)]); first_exp = int'(wpat(w0 + i)); end
            bad++;
          end
        check(bad == 0, "R5 written data", first_act, first_exp);
      end else begin
        check(rcnt - r0 == len + 1, "R7 read word count", rcnt - r0, len + 1);
        for (int i = 0; i <= len; i++)
          if (rbuf[(r0 + i) % 1024] !== mem[8'(a + i)]) begin
            if (bad == 0) begin first_act = int'(rbuf[(r0 + i) % 1024]); first_exp = int'(mem[8'(a + i)]); end
            bad++;
          end
        check(bad == 0, "R4 read data", first_act, first_exp);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5A17));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0;
    repeat (3) @(negedge clk);
    check(mem_ce_n === 1'b1, "reset ce_n", int'(mem_ce_n), 1);
    check(mem_adv_n === 1'b1, "reset adv_n", int'(mem_adv_n), 1);
    check(req_ready === 1'b0, "reset req_ready", int'(req_ready), 0);
    check(rd_valid === 1'b0 && timeout_err === 1'b0, "reset outputs", int'(rd_valid), 0);
    rst_n = 1'b1;
    while (!req_ready) @(negedge clk);
    check(cfg_cnt == 1, "R1 config write count", cfg_cnt, 1);
    check(int'(cfg_val) == exp_cfg(), "R1 config value", int'(cfg_val), exp_cfg());

    // directed
    burst(1'b0, 8'h10, 3, LAT, 0, 0, 1'b0);          // plain read
    burst(1'b1, 8'h40, 7, LAT, 7, 3, 1'b0);          // write with stall
    burst(1'b0, 8'h40, 7, 3, 5, 2, 1'b0);            // read back
    burst(1'b0, 8'h00, 0, LAT, 0, 0, 1'b0);          // single word
    burst(1'b1, 8'hF0, 31, 4, 20, 4, 1'b0);          // longest, wraps model index
    burst(1'b0, 8'hF0, 31, LAT, 0, 0, 1'b0);

    // random
    for (int i = 0; i < 12; i++) begin
      int lf, ln, s0;
      lf = 3 + int'($urandom % 5);
      ln = int'($urandom % 32);
      s0 = lf + 1 + int'($urandom % (ln + 1));
      burst(1'(($urandom) & 1), int'($urandom % 256), ln, lf, s0, int'($urandom % 5), 1'b0);
    end

    // timeout threshold
    burst(1'b0, 8'h20, 9, LAT, 7, 16, 1'b0);         // 16 active samples: fine
    burst(1'b0, 8'h20, 9, LAT, 7, 17, 1'b1);         // 17: timeout
    burst(1'b0, 8'h30, 2, LAT, 0, 0, 1'b0);          // recovers

    check(adv_lo == bursts, "R3 one strobe per burst", adv_lo, bursts);
    check(ce_falls == bursts + 1, "R3 unbroken ce per burst", ce_falls, bursts + 1);
    check(min_gap >= 2, "R2 ce high gap", min_gap, 2);
    check(ready_bad == 0, "R2 ready while busy", ready_bad, 0);
    check(early_ready == 0, "R1 ready before config", early_ready, 0);
    check(lane_bad == 0, "R6 byte lanes", lane_bad, 0);
    check(turn_bad == 0, "R8 bus turnaround", turn_bad, 0);
    check(wdrv_bad == 0, "R5 driver on during write word", wdrv_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule